// File: doc/BRIEF.md
# Storage Hot-Plug Power-Path Sequencer

This block is the timed control machine for an energy-harvesting charger. It sits after a set of analog comparators and decides when the pass switch between the storage node and the battery closes, and when the boost charger may run. All timing comes from a free-running 1 kHz tick. Each timed window counts ticks, so the windows are exact in milliseconds.

A charged element may be attached while the storage node is still near ground. The block then closes the pass switch for 45 ms to pull the storage node up and opens it again. Next it issues a single-cycle pulse that resets the feedback divider. It holds the charger off for 32 ms so the input can float to its open-circuit voltage, and strobes that voltage as the regulation reference. At 64 ms after the pulse it reconnects the battery, but only if the storage node stayed above the undervoltage level at every tick of that window. If the storage node was already above the ground threshold at attach time, the switch stays open until input power appears.

In every state, the charger enable is gated by:
- the charger-enable level comparator,
- input presence,
- an active-low enable pin,
- an overvoltage block, filtered over two ticks.

Top module: `hotplug_seq`

## Requirements
- R1: While rst_ni is low, and on the first cycle after its release, pass_en_o, fb_init_o, chg_en_o and ref_smp_o are all 0.
- R2: A rising edge of bat_hi_i while stor_hi_i is 0 closes the pass switch on the next cycle. It stays closed for exactly 45 tick pulses and opens on the cycle after the 45th.
- R3: On the cycle after the switch-on window ends, fb_init_o is 1 for exactly one clock cycle, with pass_en_o and chg_en_o both 0.
- R4: After the init pulse, chg_en_o and pass_en_o stay 0 for 64 ticks. ref_smp_o is 1 only during the 32nd tick pulse after the init pulse, and only while tick_i is 1.
- R5: If stor_uv_i is 1 at every tick of the 64 ticks after the init pulse, pass_en_o becomes 1 on the cycle after the 64th tick, and the charger is allowed.
- R6: If stor_uv_i is 0 at any tick of that window, pass_en_o stays 0 while the charger is allowed. pass_en_o becomes 1 on the cycle after stor_uv_i is next seen at 1.
- R7: Suppose a rising edge of bat_hi_i arrives while stor_hi_i is 1 and vin_ok_i is 0. Then pass_en_o, chg_en_o and fb_init_o stay 0, independent of ticks, until vin_ok_i is 1. After that the rule of R6 applies.
- R8: In the charging states, chg_en_o = stor_chg_i AND vin_ok_i AND NOT en_ni AND NOT (overvoltage block). chg_en_o is 1 in no other state.
- R9: The overvoltage block sets at a tick where stor_ov_i is 1 and was also 1 at the previous tick. It clears at the first tick where stor_ov_i is 0. An overvoltage seen at one tick only never blocks the charger.
- R10: bat_hi_i at 0 in any state returns the machine to idle on the next cycle, with all outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse each millisecond |
| bat_hi_i | input | 1 | Battery node above the ~100 mV ground threshold |
| stor_hi_i | input | 1 | Storage node above the ~100 mV ground threshold |
| stor_chg_i | input | 1 | Storage node above the charger-enable level |
| stor_uv_i | input | 1 | Storage node above the undervoltage level |
| stor_ov_i | input | 1 | Storage node at or above the overvoltage level |
| vin_ok_i | input | 1 | Harvester input present |
| en_ni | input | 1 | Active-low charger enable pin |
| pass_en_o | output | 1 | Pass-switch gate enable |
| fb_init_o | output | 1 | Feedback-divider initialization pulse |
| chg_en_o | output | 1 | Boost charger enable |
| ref_smp_o | output | 1 | Strobe to capture the input regulation reference |

## Verification
The sequence is run three ways, and each run separates different faults:
- With the undervoltage flag held high through the window. This confirms the reconnect at tick 64 and not earlier.
- With a one-tick undervoltage dip early in the window. This shows that the window is tracked tick by tick rather than only sampled at its end.
- With an attach while the storage node is already raised and no input is present. This proves the lock-out ignores ticks and releases only on input presence.

The tick position of every strobe and pulse is counted in the bench and compared to 45, 32 and 64. The charger gate is swept over all eight combinations of its three level inputs. Overvoltage is applied both as a single-tick glitch and as a sustained level, which separates the filter from a plain pass-through.

// File: rtl/hp_pkg.sv
package hp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LOCK   = 3'd1,
    ST_PLUG   = 3'd2,
    ST_INIT   = 3'd3,
    ST_BLANK  = 3'd4,
    ST_SETTLE = 3'd5,
    ST_UVWAIT = 3'd6,
    ST_RUN    = 3'd7
  } hp_state_e;
endpackage

// File: rtl/hp_tick_timer.sv
module hp_tick_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  // terminal tick: the tick that completes lim_i+1 counted ticks
  assign done_o = tick_i && !clr_i && (cnt_q == lim_i);
endmodule

// File: rtl/hp_ov_filter.sv
module hp_ov_filter (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic ov_i,
  output logic blk_o
);
  logic ov_s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ov_s_q <= 1'b0;
      blk_o  <= 1'b0;
    end else if (tick_i) begin
      ov_s_q <= ov_i;
      blk_o  <= ov_i & ov_s_q;
    end
  end
endmodule

// File: rtl/hp_seq_fsm.sv
module hp_seq_fsm
  import hp_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned PLUG_MS   = 45,
  parameter int unsigned BLANK_MS  = 32,
  parameter int unsigned SETTLE_MS = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             bat_hi_i,
  input  logic             stor_hi_i,
  input  logic             stor_uv_i,
  input  logic             vin_ok_i,
  input  logic             tmr_done_i,
  output logic             tmr_clr_o,
  output logic [CNT_W-1:0] tmr_lim_o,
  output logic             pass_en_o,
  output logic             fb_init_o,
  output logic             ref_smp_o,
  output logic             chg_allow_o
);
  localparam logic [CNT_W-1:0] PlugLim   = CNT_W'(PLUG_MS - 1);
  localparam logic [CNT_W-1:0] BlankLim  = CNT_W'(BLANK_MS - 1);
  localparam logic [CNT_W-1:0] SettleLim = CNT_W'(SETTLE_MS - 1);

  hp_state_e st_q, st_d;
  logic      bat_q;
  logic      uv_ok_q;
  logic      attach;

  assign attach = bat_hi_i & ~bat_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (attach) st_d = stor_hi_i ? (vin_ok_i ? ST_UVWAIT : ST_LOCK) : ST_PLUG;
      ST_LOCK:   if (vin_ok_i) st_d = ST_UVWAIT;
      ST_PLUG:   if (tmr_done_i) st_d = ST_INIT;
      ST_INIT:   st_d = ST_BLANK;
      ST_BLANK:  if (tmr_done_i) st_d = ST_SETTLE;
      ST_SETTLE: if (tmr_done_i) st_d = (uv_ok_q && stor_uv_i) ? ST_RUN : ST_UVWAIT;
      ST_UVWAIT: if (stor_uv_i) st_d = ST_RUN;
      ST_RUN:    st_d = ST_RUN;
      default:   st_d = ST_IDLE;
    endcase
    if (st_q != ST_IDLE && !bat_hi_i) st_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      bat_q   <= 1'b0;
      uv_ok_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      bat_q <= bat_hi_i;
      if (st_q == ST_INIT) uv_ok_q <= 1'b1;
      else if ((st_q == ST_BLANK || st_q == ST_SETTLE) && tick_i && !stor_uv_i)
        uv_ok_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_PLUG:  tmr_lim_o = PlugLim;
      ST_BLANK: tmr_lim_o = BlankLim;
      default:  tmr_lim_o = SettleLim;
    endcase
  end

  // counter runs through BLANK into SETTLE so both windows start at the init pulse
  assign tmr_clr_o   = (st_q == ST_IDLE) || (st_q == ST_INIT);
  assign pass_en_o   = (st_q == ST_PLUG) || (st_q == ST_RUN);
  assign fb_init_o   = (st_q == ST_INIT);
  assign ref_smp_o   = (st_q == ST_BLANK) && tmr_done_i;
  assign chg_allow_o = (st_q == ST_RUN) || (st_q == ST_UVWAIT);
endmodule

// File: rtl/hotplug_seq.sv
module hotplug_seq #(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned PLUG_MS   = 45,
  parameter int unsigned BLANK_MS  = 32,
  parameter int unsigned SETTLE_MS = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic bat_hi_i,
  input  logic stor_hi_i,
  input  logic stor_chg_i,
  input  logic stor_uv_i,
  input  logic stor_ov_i,
  input  logic vin_ok_i,
  input  logic en_ni,
  output logic pass_en_o,
  output logic fb_init_o,
  output logic chg_en_o,
  output logic ref_smp_o
);
  logic             tmr_clr;
  logic             tmr_done;
  logic [CNT_W-1:0] tmr_lim;
  logic             ov_blk;
  logic             chg_allow;

  hp_tick_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .clr_i  (tmr_clr),
    .lim_i  (tmr_lim),
    .done_o (tmr_done)
  );

  hp_ov_filter u_ov (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .ov_i   (stor_ov_i),
    .blk_o  (ov_blk)
  );

  hp_seq_fsm #(
    .CNT_W(CNT_W), .PLUG_MS(PLUG_MS), .BLANK_MS(BLANK_MS), .SETTLE_MS(SETTLE_MS)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .bat_hi_i    (bat_hi_i),
    .stor_hi_i   (stor_hi_i),
    .stor_uv_i   (stor_uv_i),
    .vin_ok_i    (vin_ok_i),
    .tmr_done_i  (tmr_done),
    .tmr_clr_o   (tmr_clr),
    .tmr_lim_o   (tmr_lim),
    .pass_en_o   (pass_en_o),
    .fb_init_o   (fb_init_o),
    .ref_smp_o   (ref_smp_o),
    .chg_allow_o (chg_allow)
  );

  assign chg_en_o = chg_allow & stor_chg_i & vin_ok_i & ~en_ni & ~ov_blk;
endmodule

// File: rtl/hotplug_seq_chk.sv
module hotplug_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic bat_hi_i,
  input logic stor_chg_i,
  input logic stor_ov_i,
  input logic vin_ok_i,
  input logic en_ni,
  input logic ov_blk,
  input logic pass_en_o,
  input logic fb_init_o,
  input logic chg_en_o,
  input logic ref_smp_o
);
  AST_CHG_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_en_o |-> (vin_ok_i && stor_chg_i && !en_ni)); // R8
  AST_OV_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ov_blk |-> !chg_en_o); // R9
  AST_OV_SET_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ov_blk) |-> $past(stor_ov_i) && $past(tick_i)); // R9
  AST_INIT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_init_o |=> !fb_init_o); // R3
  AST_INIT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_init_o |-> (!pass_en_o && !chg_en_o)); // R3
  AST_REF_BLACKOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_smp_o |-> (!pass_en_o && !chg_en_o && tick_i)); // R4
  AST_DETACH_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bat_hi_i |=> (!pass_en_o && !fb_init_o && !chg_en_o && !ref_smp_o)); // R10
endmodule

bind hotplug_seq hotplug_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .bat_hi_i   (bat_hi_i),
  .stor_chg_i (stor_chg_i),
  .stor_ov_i  (stor_ov_i),
  .vin_ok_i   (vin_ok_i),
  .en_ni      (en_ni),
  .ov_blk     (ov_blk),
  .pass_en_o  (pass_en_o),
  .fb_init_o  (fb_init_o),
  .chg_en_o   (chg_en_o),
  .ref_smp_o  (ref_smp_o)
);

// File: tb/tb_hotplug_seq.sv
`timescale 1ns/1ps
module tb_hotplug_seq;
  localparam int PlugMs = 45, BlankMs = 32, SettleMs = 64;

  logic clk = 1'b0, rst_ni = 1'b0, tick_i = 1'b0;
  logic bat_hi_i = 1'b0, stor_hi_i = 1'b0, stor_chg_i = 1'b1, stor_uv_i = 1'b1;
  logic stor_ov_i = 1'b0, vin_ok_i = 1'b1, en_ni = 1'b0;
  logic pass_en_o, fb_init_o, chg_en_o, ref_smp_o;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  hotplug_seq dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .bat_hi_i(bat_hi_i),
    .stor_hi_i(stor_hi_i), .stor_chg_i(stor_chg_i), .stor_uv_i(stor_uv_i),
    .stor_ov_i(stor_ov_i), .vin_ok_i(vin_ok_i), .en_ni(en_ni),
    .pass_en_o(pass_en_o), .fb_init_o(fb_init_o), .chg_en_o(chg_en_o),
    .ref_smp_o(ref_smp_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic ms();
    tick_i = 1'b1; @(posedge clk); #2; tick_i = 1'b0;
  endtask

  // run the switch-on window; returns ticks seen while pass was on
  task automatic plug_window(output int n);
    n = 0;
    while (pass_en_o && n < 200) begin ms(); n++; end
  endtask

  // 64-tick window after init; uv_dip_at: tick index where uv goes low (0 = never)
  task automatic post_init(input int uv_dip_at, input bit uv_restore,
                           output int ref_at, output int ref_n,
                           output int busy_seen, output int pass_63);
    ref_at = 0; ref_n = 0; busy_seen = 0; pass_63 = 0;
    for (int i = 1; i <= SettleMs; i++) begin
      if (i == uv_dip_at) stor_uv_i = 1'b0;
      tick_i = 1'b1; #4;
      if (ref_smp_o) begin ref_at = i; ref_n++; end
      if (chg_en_o || pass_en_o) busy_seen++;
      @(posedge clk); #2; tick_i = 1'b0;
      if (i == uv_dip_at && uv_restore) stor_uv_i = 1'b1;
      if (i == SettleMs - 1) pass_63 = pass_en_o;
    end
  endtask

  initial begin
    int n, ra, rn, bs, p63;
    repeat (3) step();
    chk("R1 pass", pass_en_o, 0); chk("R1 init", fb_init_o, 0);
    chk("R1 chg", chg_en_o, 0);   chk("R1 ref", ref_smp_o, 0);
    rst_ni = 1'b1; step();
    chk("R1 post-release pass", pass_en_o, 0);

    // valid hot-plug, uv held high
    bat_hi_i = 1'b1; step();
    chk("R2 pass on after attach", pass_en_o, 1);
    plug_window(n);
    chk("R2 switch-on ticks", n, PlugMs);
    chk("R3 init pulse", fb_init_o, 1);
    chk("R3 pass off at init", pass_en_o, 0);
    chk("R3 chg off at init", chg_en_o, 0);
    step();
    chk("R3 init single cycle", fb_init_o, 0);
    post_init(0, 1'b0, ra, rn, bs, p63);
    chk("R4 ref strobe tick", ra, BlankMs);
    chk("R4 ref strobe count", rn, 1);
    chk("R4 blackout busy", bs, 0);
    chk("R5 pass off before 64", p63, 0);
    chk("R5 pass on after 64", pass_en_o, 1);
    chk("R5 chg allowed", chg_en_o, 1);

    // R8 gating sweep
    for (int k = 0; k < 8; k++) begin
      vin_ok_i = k[0]; stor_chg_i = k[1]; en_ni = k[2]; #1;
      chk("R8 chg gate", chg_en_o, (k[0] & k[1] & ~k[2]) ? 1 : 0);
    end
    vin_ok_i = 1'b1; stor_chg_i = 1'b1; en_ni = 1'b0; step();
    chk("R8 pass stays on", pass_en_o, 1);

    // R9 single-tick glitch
    stor_ov_i = 1'b1; ms(); chk("R9 glitch tick1", chg_en_o, 1);
    stor_ov_i = 1'b0; ms(); chk("R9 glitch ignored", chg_en_o, 1);
    // sustained
    stor_ov_i = 1'b1; ms(); chk("R9 first ov tick", chg_en_o, 1);
    ms(); chk("R9 blocked", chg_en_o, 0);
    stor_ov_i = 1'b0; step(); chk("R9 held until tick", chg_en_o, 0);
    ms(); chk("R9 cleared", chg_en_o, 1);

    // R10 detach
    bat_hi_i = 1'b0; step();
    chk("R10 pass", pass_en_o, 0); chk("R10 chg", chg_en_o, 0);
    chk("R10 init", fb_init_o, 0);

    // R6 uv dip during window
    bat_hi_i = 1'b1; step();
    plug_window(n);
    chk("R2 second switch-on ticks", n, PlugMs);
    step();
    post_init(10, 1'b0, ra, rn, bs, p63);
    chk("R6 pass off after window", pass_en_o, 0);
    chk("R6 chg allowed", chg_en_o, 1);
    repeat (3) ms();
    chk("R6 pass still off", pass_en_o, 0);
    stor_uv_i = 1'b1; step();
    chk("R6 pass on at uv", pass_en_o, 1);

    // R6 one-tick dip then recovery: still no reconnect at tick 64
    bat_hi_i = 1'b0; step(); bat_hi_i = 1'b1; step();
    plug_window(n); step();
    post_init(20, 1'b1, ra, rn, bs, p63);
    chk("R6 dip blocks reconnect", pass_en_o, 0);
    step();
    chk("R6 reconnect after uv seen", pass_en_o, 1);

    // R7 lock-out
    bat_hi_i = 1'b0; step();
    stor_hi_i = 1'b1; vin_ok_i = 1'b0; bat_hi_i = 1'b1; step();
    chk("R7 pass locked", pass_en_o, 0);
    repeat (80) ms();
    chk("R7 pass still locked", pass_en_o, 0);
    chk("R7 no init pulse", fb_init_o, 0);
    chk("R7 chg off", chg_en_o, 0);
    vin_ok_i = 1'b1; step(); step();
    chk("R7 released on input", pass_en_o, 1);
    chk("R7 chg after release", chg_en_o, 1);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule